// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns a parallel character into an asynchronous serial frame. It paces every bit with a single-cycle tick that runs at sixteen times the bit rate. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a programmable stop period. Characters come in on a valid/ready stream into a one-entry holding register. The next character can therefore be accepted while the current one is still being shifted out. A character that is waiting starts the moment the previous stop period ends.

Two diagnostic controls act on the output stage only. A forced-break input drives the line low at once. A loopback input sends the serial stream to an internal return pin and keeps the external line idle. Back-pressure rule: `in_ready` is high exactly when the holding register is empty. A character is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_data` has to stay stable only in that cycle. The configuration inputs are captured when a character moves from the holding register into the shifter, so changes during a frame apply to the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `loop_out` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A frame begins with a start bit of 0 that lasts 16 ticks, followed by the data bits least significant bit first, each lasting 16 ticks.
- R3: `len_sel` gives the number of data bits as 5 + `len_sel` (0→5, 3→8); data bits above that count are never sent.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd`=0 it makes the count of ones in data plus parity even; with `par_odd`=1 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R5: `stop_sel` sets the stop period: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks. The line is 1 throughout the stop period.
- R6: `in_ready` is 1 exactly when the holding register is empty. After an accepted transfer, `in_ready` is 0 in the next cycle. It stays 0 while a second character waits behind a frame that is in progress.
- R7: A character waiting in the holding register starts its start bit in the cycle right after the last stop tick, with no idle time in between.
- R8: Bit timing advances only on cycles where `tick16` is 1. With no ticks, the line holds its level.
- R9: While `brk_force` is 1, `tx_line` is 0, whatever else is happening.
- R10: While `loop_en` is 1 and `brk_force` is 0, `tx_line` is 1 and `loop_out` carries the serial frame. While `loop_en` is 0, `loop_out` is 1.
- R11: `busy` is 1 while a frame is being sent or a character is waiting in the holding register, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding register empty |
| in_data | input | 8 | Character, bit 0 sent first |
| len_sel | input | 2 | Data length code, bits = 5 + code |
| par_en | input | 1 | Send a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_sel | input | 2 | Stop period code: 0 = 16, 1 = 24, 2/3 = 32 ticks |
| brk_force | input | 1 | Force the line low |
| loop_en | input | 1 | Route the frame to `loop_out`, idle the line |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress or character waiting |
| loop_out | output | 1 | Internal return path to the receiver |

## Verification
The assertions check on every cycle the rules for the output stage and the handshake. These are: break forcing the line low, loopback keeping the line high and the return path high outside loopback, the ready drop after an accepted transfer, the busy/ready relation, and a low line holding its level when no tick arrives. The bench scenarios are the only place where whole-frame behaviour is shown. That covers bit order and the 16-tick bit period, truncation of data to the chosen length, even and odd parity values, and the exact 16/24/32-tick stop periods. It also covers back-to-back frames with no gap, slowed tick rates, and a frame read back through the loopback pin.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } seq_state_t;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop_code;
  } frame_cfg_t;
endpackage

// File: rtl/uft_holding.sv
module uft_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);
  logic accept;

  assign in_ready = !hold_full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/uft_frame_seq.sv
module uft_frame_seq
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        cfg,
  output logic              take,
  output logic              serial_bit,
  output logic              active
);
  localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;
  localparam int CNT_W   = $clog2(2 * TICKS);
  localparam int IDX_W   = $clog2(DATA_W);

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_last;
  logic [CNT_W-1:0]  stop_last;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  nbits_m1;
  logic [IDX_W-1:0]  nbits_in_m1;
  logic [DATA_W-1:0] shreg;
  frame_cfg_t        cfg_q;
  logic              par_q;
  logic              par_next;
  logic              start_now;

  always_comb begin
    unique case (cfg_q.stop_code)
      2'd0:    stop_last = CNT_W'(TICKS - 1);
      2'd1:    stop_last = CNT_W'(TICKS + TICKS / 2 - 1);
      default: stop_last = CNT_W'(2 * TICKS - 1);
    endcase
  end

  assign cnt_last    = (state == ST_STOP) ? stop_last : CNT_W'(TICKS - 1);
  assign nbits_m1    = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_q.len_code);
  assign nbits_in_m1 = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg.len_code);

  always_comb begin
    par_next = cfg.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i <= int'(nbits_in_m1)) par_next = par_next ^ hold_data[i];
    end
  end

  assign start_now = hold_full &&
                     ((state == ST_IDLE) ||
                      (state == ST_STOP && tick && cnt == cnt_last));
  assign take   = start_now;
  assign active = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
    end else if (start_now) begin
      state <= ST_START;
      cnt   <= '0;
      idx   <= '0;
      shreg <= hold_data;
      cfg_q <= cfg;
      par_q <= par_next;
    end else if (tick && state != ST_IDLE) begin
      if (cnt != cnt_last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
            if (idx == nbits_m1) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_START: serial_bit = 1'b0;
      ST_DATA:  serial_bit = shreg[0];
      ST_PAR:   serial_bit = par_q;
      default:  serial_bit = 1'b1;
    endcase
  end
endmodule

// File: rtl/uft_line_out.sv
module uft_line_out (
  input  logic serial_bit,
  input  logic brk_force,
  input  logic loop_en,
  output logic tx_line,
  output logic loop_out
);
  logic shaped;

  assign shaped   = serial_bit && !brk_force;
  assign tx_line  = loop_en ? !brk_force : shaped;
  assign loop_out = loop_en ? shaped : 1'b1;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 2,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  len_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic              brk_force,
  input  logic              loop_en,
  output logic              tx_line,
  output logic              busy,
  output logic              loop_out
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              serial_bit;
  logic              active;
  frame_cfg_t        cfg;

  assign cfg.len_code  = 2'(len_sel);
  assign cfg.par_en    = par_en;
  assign cfg.par_odd   = par_odd;
  assign cfg.stop_code = stop_sel;

  uft_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .take(take), .hold_full(hold_full), .hold_data(hold_data)
  );

  uft_frame_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .TICKS(TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .hold_full(hold_full),
    .hold_data(hold_data), .cfg(cfg), .take(take), .serial_bit(serial_bit),
    .active(active)
  );

  uft_line_out u_out (
    .serial_bit(serial_bit), .brk_force(brk_force), .loop_en(loop_en),
    .tx_line(tx_line), .loop_out(loop_out)
  );

  assign busy = active || hold_full;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic in_valid,
  input logic in_ready,
  input logic brk_force,
  input logic loop_en,
  input logic tx_line,
  input logic busy,
  input logic loop_out
);
  a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk_force |-> !tx_line);

  a_r10_loop_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !brk_force) |-> tx_line);

  a_r10_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> loop_out);

  a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  a_r8_hold_low_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!tick16 && !tx_line && !brk_force && !loop_en) && !brk_force && !loop_en)
      |-> !tx_line);
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
  .in_ready(in_ready), .brk_force(brk_force), .loop_en(loop_en),
  .tx_line(tx_line), .busy(busy), .loop_out(loop_out)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic       brk_force = 1'b0;
  logic       loop_en = 1'b0;
  logic       tx_line, busy, loop_out;

  int errors = 0;
  int checks = 0;
  int tick_period = 1;
  bit tick_on = 1'b1;
  int tick_cnt = 0;
  bit done = 1'b0;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .len_sel(len_sel),
    .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .brk_force(brk_force), .loop_en(loop_en), .tx_line(tx_line),
    .busy(busy), .loop_out(loop_out)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tick16 = tick_on && (tick_cnt == 0);
      tick_cnt = (tick_cnt + 1) % tick_period;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic watched(input bit use_loop);
    return use_loop ? loop_out : tx_line;
  endfunction

  task automatic decode(input bit use_loop, input int p, input int nbits, input bit with_par,
                        output logic [7:0] data, output logic par_bit,
                        output int stop_len, output bit start_ok);
    int wait_n = 0;
    data = '0;
    par_bit = 1'b0;
    while (watched(use_loop) != 1'b0 && wait_n < 400 * p) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (8 * p) @(negedge clk);
    start_ok = (watched(use_loop) == 1'b0);
    for (int k = 0; k < nbits; k++) begin
      repeat (16 * p) @(negedge clk);
      data[k] = watched(use_loop);
    end
    if (with_par) begin
      repeat (16 * p) @(negedge clk);
      par_bit = watched(use_loop);
    end
    repeat (8 * p) @(negedge clk);
    stop_len = 0;
    while (watched(use_loop) == 1'b1 && stop_len < 48 * p) begin
      stop_len++;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    check(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
    check(loop_out == 1'b1, "R1 loop_out", loop_out, 1);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
  endtask

  task automatic test_basic();
    logic [7:0] d; logic pb; int sl; bit so;
    len_sel = 2'd3; par_en = 1'b0; stop_sel = 2'd0;
    send(8'hA5);
    decode(1'b0, 1, 8, 1'b0, d, pb, sl, so);
    check(so, "R2 start bit low", so, 1);
    check(d == 8'hA5, "R2 data lsb first", d, 8'hA5);
    check(sl >= 16, "R5 stop high after idle", sl, 16);
    check(busy == 1'b0, "R11 busy clear when idle", busy, 0);
  endtask

  task automatic test_lengths();
    logic [7:0] d; logic pb; int sl; bit so;
    for (int l = 0; l < 4; l++) begin
      len_sel = 2'(l);
      send(8'h6B ^ 8'(l * 8'h11) | 8'hE0);
      decode(1'b0, 1, 5 + l, 1'b0, d, pb, sl, so);
      check(d == ((8'h6B ^ 8'(l * 8'h11) | 8'hE0) & 8'((1 << (5 + l)) - 1)),
            "R3 data length", d, (8'h6B ^ 8'(l * 8'h11) | 8'hE0) & ((1 << (5 + l)) - 1));
      check(sl >= 16, "R3 stop follows last data bit", sl, 16);
    end
    len_sel = 2'd3;
  endtask

  task automatic test_parity();
    logic [7:0] d; logic pb; int sl; bit so;
    logic [7:0] vals [2] = '{8'h5A, 8'h3B};
    for (int o = 0; o < 2; o++) begin
      for (int v = 0; v < 2; v++) begin
        len_sel = 2'd2; par_en = 1'b1; par_odd = o[0];
        send(vals[v]);
        decode(1'b0, 1, 7, 1'b1, d, pb, sl, so);
        check(d == (vals[v] & 8'h7F), "R4 data with parity", d, vals[v] & 8'h7F);
        check(pb == ((^(vals[v] & 8'h7F)) ^ o[0]), "R4 parity bit", pb,
              (^(vals[v] & 8'h7F)) ^ o[0]);
      end
    end
    par_en = 1'b0; par_odd = 1'b0; len_sel = 2'd3;
  endtask

  task automatic test_stops();
    logic [7:0] d; logic pb; int sl; bit so;
    int exp_len [4] = '{16, 24, 32, 32};
    for (int s = 0; s < 4; s++) begin
      stop_sel = 2'(s);
      send(8'h81);
      fork send(8'h7E); join_none
      decode(1'b0, 1, 8, 1'b0, d, pb, sl, so);
      check(d == 8'h81, "R5 first frame data", d, 8'h81);
      check(sl == exp_len[s], "R5 R7 stop length without gap", sl, exp_len[s]);
      decode(1'b0, 1, 8, 1'b0, d, pb, sl, so);
      check(so, "R7 second start bit", so, 1);
      check(d == 8'h7E, "R7 second frame data", d, 8'h7E);
    end
    stop_sel = 2'd0;
  endtask

  task automatic test_handshake();
    send(8'h33);
    check(in_ready == 1'b0, "R6 ready drops after accept", in_ready, 0);
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    @(negedge clk);
    check(in_ready == 1'b1, "R6 ready after move to shifter", in_ready, 1);
    send(8'h44);
    repeat (40) @(negedge clk);
    check(in_ready == 1'b0, "R6 ready low while second waits", in_ready, 0);
    while (busy) @(negedge clk);
    check(in_ready == 1'b1, "R6 ready after both frames", in_ready, 1);
  endtask

  task automatic test_tick();
    logic [7:0] d; logic pb; int sl; bit so;
    tick_on = 1'b0;
    send(8'hC6);
    repeat (60) @(negedge clk);
    check(tx_line == 1'b0, "R8 start bit held without ticks", tx_line, 0);
    check(busy == 1'b1, "R8 busy held without ticks", busy, 1);
    tick_period = 3; tick_cnt = 0; tick_on = 1'b1;
    decode(1'b0, 3, 8, 1'b0, d, pb, sl, so);
    check(d == 8'hC6, "R8 data at slow tick", d, 8'hC6);
    while (busy) @(negedge clk);
    tick_period = 1; tick_cnt = 0;
  endtask

  task automatic test_break();
    brk_force = 1'b1;
    @(negedge clk);
    check(tx_line == 1'b0, "R9 break forces low", tx_line, 0);
    check(loop_out == 1'b1, "R10 return idle outside loopback", loop_out, 1);
    repeat (20) @(negedge clk);
    check(tx_line == 1'b0, "R9 break held", tx_line, 0);
    brk_force = 1'b0;
    @(negedge clk);
    check(tx_line == 1'b1, "R9 line released", tx_line, 1);
  endtask

  task automatic test_loop();
    logic [7:0] d; logic pb; int sl; bit so;
    int lows = 0;
    bit mon = 1'b1;
    loop_en = 1'b1;
    fork
      while (mon) begin
        @(negedge clk);
        if (!tx_line) lows++;
      end
    join_none
    send(8'h2D);
    decode(1'b1, 1, 8, 1'b0, d, pb, sl, so);
    mon = 1'b0;
    check(d == 8'h2D, "R10 frame on return path", d, 8'h2D);
    check(lows == 0, "R10 external line idle in loopback", lows, 0);
    loop_en = 1'b0;
    @(negedge clk);
    check(loop_out == 1'b1, "R10 return idle after loopback", loop_out, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_basic();
    test_lengths();
    test_parity();
    test_stops();
    while (busy) @(negedge clk);
    test_handshake();
    test_tick();
    test_break();
    test_loop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule